// File: doc/BRIEF.md
# LPC I/O cycle engine

This block runs bursts of single-byte LPC I/O cycles on behalf of a processor. Software sets the number of byte cycles, the direction, whether the port address stays fixed or steps by one per cycle, and the starting port address. For a write it also queues the data bytes. A write of 1 to the go register then starts the burst. The engine drives LAD[3:0] and LFRAME# one nibble per clock, handles the target's SYNC handshake including long waits, and places the bytes it reads into a read queue. When the burst ends, two status flags tell software whether every cycle completed or the burst was aborted.

The bus runs on the block's own clock, so one clock is one LPC clock. A burst is aborted when the target signals an error, when it keeps waiting too long, or when it returns nonsense on the SYNC nibble. An aborted burst issues no further cycles. Bytes go out and come back in queue order, so the first queue entry belongs to the lowest address, which gives little-endian order for a multi-byte access.

Top module: `lpc_io_engine`

## Requirements
- R1: After reset the status register (offset 0x04) reads idle=1 (bit 0) and ok=0 (bit 1), LFRAME# is high and the engine does not drive LAD.
- R2: A go write (offset 0x00, bit 0 set) while idle with a nonzero count makes idle read 0 from the next clock and clears ok. After a burst in which every cycle completed, status reads idle=1 and ok=1.
- R3: Each cycle starts with exactly one clock of LFRAME# low and LAD=0000. The next nibble is 0000 for a read or 0010 for a write (command bit 0: 1=write), followed by the 16-bit port address as four nibbles, most significant first.
- R4: A write cycle sends its byte as two nibbles, low nibble first. Bytes are taken from the write queue (offset 0x24, byte in bits 7:0) in the order they were pushed.
- R5: With command bit 3 set, every cycle of the burst uses the programmed address (offset 0x20). With it clear, the address grows by one per cycle.
- R6: After SYNC 0000 a read cycle takes two nibbles from the target, low first, and appends the byte to the read queue. Each read of offset 0x28 returns and removes the oldest byte, and an empty queue reads 0.
- R7: After the address or write data, the host drives 1111 for one clock and then stops driving LAD. It does not drive LAD during SYNC, read data or the two closing turnaround clocks.
- R8: SYNC 0101 or 0110 extends the cycle. Up to 255 consecutive wait nibbles followed by 0000 still complete the cycle normally.
- R9: The 256th consecutive wait nibble in one cycle aborts the burst. Status then reads idle=1 and ok=0, and no further cycle starts.
- R10: SYNC 1010 aborts the burst with idle=1 and ok=0, and no further cycle starts.
- R11: Four consecutive SYNC nibbles that are neither ready, wait nor error abort the burst. Three of them followed by 0000 do not.
- R12: A go write while a burst runs has no effect: the running burst issues exactly its latched count of cycles and the read queue keeps its bytes.
- R13: A go write clears the read queue, and the write queue is emptied when a burst ends or aborts, so stale bytes never reach a later burst.
- R14: A burst issues exactly the programmed number of cycles (count at offset 0x10). A count of 0 issues none and leaves status at idle=1, ok=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and LPC clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the read queue at 0x28) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| lpc_lad_in | input | 4 | LAD value seen from the bus |
| lpc_lad_out | output | 4 | LAD value driven by the host |
| lpc_lad_oe | output | 1 | Host drives LAD when high |
| lpc_frame_n | output | 1 | LFRAME#, active low |

## Verification
The bench goes after the wait counter at its edge: 255 waits must still complete, and 256 must abort. A counter that is off by one either kills a slow but valid target or hangs one clock too long. It checks that three invalid SYNC nibbles are tolerated and four abort, and that an error SYNC in the middle of a burst stops all later cycles, which a design that only records the error would not do. It also fires a second go into a running burst and starts bursts over leftover bytes in both queues. A design that restarts on that go, or that does not empty the queues, shows extra frames or stale data at the pins and on the read port.

// File: rtl/lpc_io_engine.sv
module lpc_io_engine #(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 5,
  parameter int FIFO_DEPTH = 16,
  parameter int WAIT_LIMIT = 256,
  parameter int BAD_LIMIT  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [3:0]  lpc_lad_in,
  output logic [3:0]  lpc_lad_out,
  output logic        lpc_lad_oe,
  output logic        lpc_frame_n
);
  localparam int ADDR_NIB = ADDR_W / 4;
  localparam int NI_W = (ADDR_NIB > 1) ? $clog2(ADDR_NIB) : 1;
  localparam int FP_W = $clog2(FIFO_DEPTH);
  localparam int FC_W = $clog2(FIFO_DEPTH + 1);
  localparam int WC_W = $clog2(WAIT_LIMIT + 1);
  localparam int BC_W = $clog2(BAD_LIMIT + 1);

  localparam logic [7:0] OFS_GO    = 8'h00;
  localparam logic [7:0] OFS_STAT  = 8'h04;
  localparam logic [7:0] OFS_CNT   = 8'h10;
  localparam logic [7:0] OFS_CMD   = 8'h14;
  localparam logic [7:0] OFS_ADDR  = 8'h20;
  localparam logic [7:0] OFS_WFIFO = 8'h24;
  localparam logic [7:0] OFS_RFIFO = 8'h28;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_CTYPE, ST_ADDR, ST_WDATA, ST_TAR1, ST_TAR2,
    ST_SYNC, ST_RDATA, ST_TARB1, ST_TARB2
  } state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt_q, rem;
  logic              cmd_wr_q, cmd_fix_q, run_wr, run_fix;
  logic [31:0]       addr_q;
  logic [ADDR_W-1:0] cur_addr;
  logic [7:0]        cur_byte;
  logic [NI_W-1:0]   nib;
  logic              half;
  logic              fin_q;
  logic [WC_W-1:0]   wait_cnt;
  logic [BC_W-1:0]   bad_cnt;

  logic [7:0]      wmem [FIFO_DEPTH];
  logic [FP_W-1:0] wrp, wwp;
  logic [FC_W-1:0] wcount;
  logic [7:0]      rmem [FIFO_DEPTH];
  logic [FP_W-1:0] rrp, rwp;
  logic [FC_W-1:0] rcount;

  wire idle    = (state == ST_IDLE);
  wire in_sync = (state == ST_SYNC);
  wire wr_go   = reg_wr && reg_addr == OFS_GO && reg_wdata[0];
  wire go      = wr_go && idle;

  wire s_ready = (lpc_lad_in == 4'h0);
  wire s_wait  = (lpc_lad_in == 4'h5) || (lpc_lad_in == 4'h6);
  wire s_err   = (lpc_lad_in == 4'hA);
  wire s_bad   = !s_ready && !s_wait && !s_err;

  wire abort = in_sync && (s_err ||
               (s_wait && wait_cnt == WC_W'(WAIT_LIMIT - 1)) ||
               (s_bad && bad_cnt == BC_W'(BAD_LIMIT - 1)));
  wire last_cyc  = (rem == CNT_W'(1));
  wire burst_end = (state == ST_TARB2) && last_cyc;

  wire wpush  = reg_wr && reg_addr == OFS_WFIFO && wcount != FC_W'(FIFO_DEPTH);
  wire wpop   = (state == ST_START) && run_wr && wcount != '0;
  wire wflush = burst_end || abort;
  wire rpush  = (state == ST_RDATA) && half && rcount != FC_W'(FIFO_DEPTH);
  wire rpop   = reg_rd && reg_addr == OFS_RFIFO && rcount != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; cmd_wr_q <= 1'b0; cmd_fix_q <= 1'b0; addr_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_CNT:  cnt_q <= reg_wdata[CNT_W-1:0];
        OFS_CMD:  begin cmd_wr_q <= reg_wdata[0]; cmd_fix_q <= reg_wdata[3]; end
        OFS_ADDR: addr_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) if (wpush) wmem[wwp] <= reg_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrp <= '0; wwp <= '0; wcount <= '0;
    end else if (wflush) begin
      wrp <= '0; wwp <= '0; wcount <= '0;
    end else begin
      if (wpush) wwp <= wwp + FP_W'(1);
      if (wpop)  wrp <= wrp + FP_W'(1);
      wcount <= wcount + FC_W'(wpush) - FC_W'(wpop);
    end
  end

  always_ff @(posedge clk) if (rpush) rmem[rwp] <= {lpc_lad_in, cur_byte[3:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rrp <= '0; rwp <= '0; rcount <= '0;
    end else if (go) begin
      rrp <= '0; rwp <= '0; rcount <= '0;
    end else begin
      if (rpush) rwp <= rwp + FP_W'(1);
      if (rpop)  rrp <= rrp + FP_W'(1);
      rcount <= rcount + FC_W'(rpush) - FC_W'(rpop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; fin_q <= 1'b0; rem <= '0; cur_addr <= '0;
      cur_byte <= '0; nib <= '0; half <= 1'b0; wait_cnt <= '0; bad_cnt <= '0;
      run_wr <= 1'b0; run_fix <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (go) begin
          run_wr   <= cmd_wr_q;
          run_fix  <= cmd_fix_q;
          cur_addr <= addr_q[ADDR_W-1:0];
          rem      <= cnt_q;
          if (cnt_q == '0) fin_q <= 1'b1;
          else begin fin_q <= 1'b0; state <= ST_START; end
        end
        ST_START: begin
          cur_byte <= (run_wr && wcount != '0) ? wmem[wrp] : 8'h00;
          state    <= ST_CTYPE;
        end
        ST_CTYPE: begin nib <= '0; state <= ST_ADDR; end
        ST_ADDR: begin
          if (nib == NI_W'(ADDR_NIB - 1)) begin
            half  <= 1'b0;
            state <= run_wr ? ST_WDATA : ST_TAR1;
          end else nib <= nib + NI_W'(1);
        end
        ST_WDATA: if (half) state <= ST_TAR1; else half <= 1'b1;
        ST_TAR1: state <= ST_TAR2;
        ST_TAR2: begin wait_cnt <= '0; bad_cnt <= '0; state <= ST_SYNC; end
        ST_SYNC: begin
          if (abort) state <= ST_IDLE;
          else if (s_ready) begin
            half  <= 1'b0;
            state <= run_wr ? ST_TARB1 : ST_RDATA;
          end else if (s_wait) begin
            wait_cnt <= wait_cnt + WC_W'(1);
            bad_cnt  <= '0;
          end else bad_cnt <= bad_cnt + BC_W'(1);
        end
        ST_RDATA: begin
          if (!half) begin cur_byte[3:0] <= lpc_lad_in; half <= 1'b1; end
          else state <= ST_TARB1;
        end
        ST_TARB1: state <= ST_TARB2;
        ST_TARB2: begin
          if (last_cyc) begin
            state <= ST_IDLE;
            fin_q <= 1'b1;
          end else begin
            rem <= rem - CNT_W'(1);
            if (!run_fix) cur_addr <= cur_addr + ADDR_W'(1);
            state <= ST_START;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign lpc_frame_n = (state != ST_START);
  assign lpc_lad_oe  = (state == ST_START) || (state == ST_CTYPE) || (state == ST_ADDR) ||
                       (state == ST_WDATA) || (state == ST_TAR1);

  always_comb begin
    int sel;
    sel = (ADDR_NIB - 1 - int'(nib)) * 4;
    case (state)
      ST_START: lpc_lad_out = 4'h0;
      ST_CTYPE: lpc_lad_out = run_wr ? 4'h2 : 4'h0;
      ST_ADDR:  lpc_lad_out = cur_addr[sel +: 4];
      ST_WDATA: lpc_lad_out = half ? cur_byte[7:4] : cur_byte[3:0];
      default:  lpc_lad_out = 4'hF;
    endcase
  end

  always_comb begin
    case (reg_addr)
      OFS_STAT:  reg_rdata = {30'd0, fin_q, idle};
      OFS_CNT:   reg_rdata = 32'(cnt_q);
      OFS_CMD:   reg_rdata = {28'd0, cmd_fix_q, 2'b00, cmd_wr_q};
      OFS_ADDR:  reg_rdata = addr_q;
      OFS_RFIFO: reg_rdata = (rcount != '0) ? {24'd0, rmem[rrp]} : 32'd0;
      default:   reg_rdata = 32'd0;
    endcase
  end
endmodule

module lpc_io_engine_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             idle,
  input logic             fin,
  input logic             wr_go,
  input logic             in_sync,
  input logic [CNT_W-1:0] cnt,
  input logic [3:0]       lad_in,
  input logic [3:0]       lad_out,
  input logic             lad_oe,
  input logic             frame_n
);
  assert_bus_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> frame_n && !lad_oe);
  assert_go_leaves_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && idle && cnt != '0) |=> !idle);
  assert_busy_not_ok_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> !fin);
  assert_start_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |-> lad_oe && lad_out == 4'h0);
  assert_frame_one_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> frame_n && lad_oe);
  assert_released_in_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_sync |-> !lad_oe);
  assert_error_aborts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sync && lad_in == 4'hA) |=> idle && !fin);
  assert_count_zero_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && idle && cnt == '0) |=> idle && fin);
endmodule

bind lpc_io_engine lpc_io_engine_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle(idle), .fin(fin_q), .wr_go(wr_go),
  .in_sync(in_sync), .cnt(cnt_q), .lad_in(lpc_lad_in), .lad_out(lpc_lad_out),
  .lad_oe(lpc_lad_oe), .frame_n(lpc_frame_n)
);

// File: tb/tb_lpc_io_engine.sv
module tb_lpc_io_engine;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, reg_wr, reg_rd;
  logic [7:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [3:0] lad_in, lad_out;
  logic lad_oe, frame_n;

  lpc_io_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lpc_lad_in(lad_in), .lpc_lad_out(lad_out), .lpc_lad_oe(lad_oe),
    .lpc_frame_n(frame_n)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference model of the bus: phases of one cycle as seen by a target
  localparam int P_IDLE = 0, P_STARTX = 1, P_CT = 2, P_AD = 3, P_WD = 4, P_T1 = 5,
                 P_T2 = 6, P_SY = 7, P_RD = 8, P_B1 = 9, P_B2 = 10;
  int p = P_IDLE, k = 0, pending = 0, issued = 0, wcnt = 0, bcnt = 0;
  bit exp_wr = 0, exp_fix = 0, model_ok = 1;
  logic [15:0] cur_a;
  logic [7:0] curb;
  logic [7:0] wq[$];
  logic [7:0] rsrc[$];
  logic [7:0] rexp[$];
  logic [3:0] sync_q[$];

  task automatic begin_cycle();
    chk(lad_oe && lad_out == 4'h0, "R3", "start nibble", lad_out, 0);
    issued++;
    curb = (exp_wr && wq.size() > 0) ? wq.pop_front() : 8'h00;
    p = P_CT;
  endtask

  task automatic model_abort();
    p = P_IDLE; pending = 0; model_ok = 0; wq.delete();
  endtask

  task automatic model_step();
    logic [3:0] n;
    lad_in = 4'hF;
    case (p)
      P_IDLE:
        if (!frame_n) begin
          chk(pending > 0, "R14", "unexpected cycle start", issued, 0);
          begin_cycle();
        end else chk(!lad_oe, "R1", "lad driven while idle", lad_oe, 0);
      P_STARTX: begin
        chk(!frame_n, "R14", "next cycle start", frame_n, 0);
        begin_cycle();
      end
      P_CT: begin
        chk(frame_n && lad_oe && lad_out == (exp_wr ? 4'h2 : 4'h0), "R3", "cycle type",
            lad_out, exp_wr ? 2 : 0);
        p = P_AD; k = 0;
      end
      P_AD: begin
        n = cur_a[12 - 4*k +: 4];
        chk(lad_oe && lad_out == n, "R5", "address nibble", lad_out, n);
        k++;
        if (k == 4) begin k = 0; p = exp_wr ? P_WD : P_T1; end
      end
      P_WD: begin
        n = (k == 0) ? curb[3:0] : curb[7:4];
        chk(lad_oe && lad_out == n, "R4", "write nibble", lad_out, n);
        if (k == 1) p = P_T1; else k = 1;
      end
      P_T1: begin
        chk(lad_oe && lad_out == 4'hF, "R7", "turnaround drive", lad_out, 15);
        p = P_T2;
      end
      P_T2: begin
        chk(!lad_oe, "R7", "released after turnaround", lad_oe, 0);
        p = P_SY; wcnt = 0; bcnt = 0;
      end
      P_SY: begin
        chk(!lad_oe && frame_n, "R7", "host quiet in sync", lad_oe, 0);
        n = (sync_q.size() > 0) ? sync_q.pop_front() : 4'h0;
        lad_in = n;
        if (n == 4'h0) begin p = exp_wr ? P_B1 : P_RD; k = 0; end
        else if (n == 4'h5 || n == 4'h6) begin
          wcnt++; bcnt = 0;
          if (wcnt == 256) model_abort();
        end else if (n == 4'hA) model_abort();
        else begin
          bcnt++;
          if (bcnt == 4) model_abort();
        end
      end
      P_RD: begin
        chk(!lad_oe, "R7", "host quiet in read data", lad_oe, 0);
        if (k == 0) begin
          curb = (rsrc.size() > 0) ? rsrc.pop_front() : 8'h00;
          lad_in = curb[3:0]; k = 1;
        end else begin
          lad_in = curb[7:4];
          rexp.push_back(curb);
          p = P_B1;
        end
      end
      P_B1: begin
        chk(!lad_oe, "R7", "closing turnaround", lad_oe, 0);
        p = P_B2;
      end
      P_B2: begin
        chk(!lad_oe, "R7", "closing turnaround", lad_oe, 0);
        pending--;
        if (!exp_fix) cur_a = cur_a + 16'd1;
        if (pending > 0) p = P_STARTX;
        else begin p = P_IDLE; wq.delete(); end
      end
      default: p = P_IDLE;
    endcase
  endtask

  initial begin
    lad_in = 4'hF;
    forever begin
      @(negedge clk);
      if (rst_n) model_step();
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #2 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic push_w(input logic [7:0] b);
    wr_reg(8'h24, {24'd0, b});
    wq.push_back(b);
  endtask

  task automatic run_burst(input bit wr, input bit fix, input int addr, input int n,
                           input int exp_cyc, input bit exp_ok, input bit poke,
                           input string req);
    logic [31:0] s;
    exp_wr = wr; exp_fix = fix; cur_a = 16'(addr); pending = n; issued = 0; model_ok = 1;
    if (!wr) rexp.delete();
    wr_reg(8'h10, 32'(n));
    wr_reg(8'h14, {28'd0, fix, 2'b00, wr});
    wr_reg(8'h20, 32'(addr));
    wr_reg(8'h00, 32'd1);
    if (poke) begin
      wr_reg(8'h10, 32'd5);
      wr_reg(8'h00, 32'd1);
    end
    rd_reg(8'h04, s);
    if (n != 0) chk(s[0] == 1'b0, "R2", "idle low while busy", s, 0);
    for (int i = 0; i < 3000 && !s[0]; i++) rd_reg(8'h04, s);
    chk(s[1:0] == {exp_ok, 1'b1}, req, "final status", s[1:0], {exp_ok, 1'b1});
    chk(model_ok == exp_ok, req, "target view of outcome", model_ok, exp_ok);
    chk(issued == exp_cyc, "R14", "cycles issued", issued, exp_cyc);
  endtask

  task automatic pop_r(input logic [7:0] exp, input string req);
    logic [31:0] d;
    rd_reg(8'h28, d);
    chk(d == {24'd0, exp}, req, "read queue byte", d, exp);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [31:0] s;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #3;
    chk(frame_n && !lad_oe, "R1", "bus after reset", {frame_n, lad_oe}, 2);
    rd_reg(8'h04, s);
    chk(s == 32'd1, "R1", "status after reset", s, 1);

    // R4 R5: incrementing write burst
    push_w(8'h11); push_w(8'h22); push_w(8'h33); push_w(8'h44);
    run_burst(1, 0, 16'h0080, 4, 4, 1, 0, "R2");
    pop_r(8'h00, "R6");

    // R5 R8: fixed-address write with waits
    push_w(8'hAA); push_w(8'hBB); push_w(8'hCC);
    sync_q = '{4'h5, 4'h6, 4'h0, 4'h0, 4'h6, 4'h0};
    run_burst(1, 1, 16'h00E4, 3, 3, 1, 0, "R8");

    // R6: incrementing read burst, little-endian queue order
    rsrc = '{8'hA5, 8'h3C, 8'h0F, 8'hF0};
    run_burst(0, 0, 16'h02F8, 4, 4, 1, 0, "R6");
    pop_r(8'hA5, "R6"); pop_r(8'h3C, "R6"); pop_r(8'h0F, "R6"); pop_r(8'hF0, "R6");
    pop_r(8'h00, "R6");

    // R8: 255 waits still complete
    sync_q.delete();
    for (int i = 0; i < 255; i++) sync_q.push_back(4'h5);
    sync_q.push_back(4'h0);
    rsrc = '{8'h5A};
    run_burst(0, 1, 16'h0060, 1, 1, 1, 0, "R8");
    pop_r(8'h5A, "R8");

    // R9: 256 waits abort, no later cycles
    sync_q.delete();
    for (int i = 0; i < 256; i++) sync_q.push_back(4'h6);
    rsrc = '{8'h01, 8'h02, 8'h03};
    run_burst(0, 1, 16'h0060, 3, 1, 0, 0, "R9");
    pop_r(8'h00, "R9");
    sync_q.delete(); rsrc.delete();

    // R10: error sync on the second cycle
    push_w(8'h01); push_w(8'h02); push_w(8'h03);
    sync_q = '{4'h0, 4'hA};
    run_burst(1, 0, 16'h0100, 3, 2, 0, 0, "R10");
    // R13: leftover write byte must not reach the next burst
    push_w(8'h7E);
    run_burst(1, 0, 16'h0100, 1, 1, 1, 0, "R13");

    // R11: four invalid sync nibbles abort, three do not
    sync_q = '{4'h3, 4'hF, 4'hC, 4'h9};
    run_burst(0, 0, 16'h0200, 1, 1, 0, 0, "R11");
    sync_q = '{4'h3, 4'hF, 4'hC, 4'h0};
    rsrc = '{8'h99};
    run_burst(0, 0, 16'h0200, 1, 1, 1, 0, "R11");
    pop_r(8'h99, "R11");

    // R12: go during a running burst is ignored
    sync_q.delete();
    for (int i = 0; i < 30; i++) sync_q.push_back(4'h6);
    sync_q.push_back(4'h0); sync_q.push_back(4'h0);
    rsrc = '{8'h11, 8'h22};
    run_burst(0, 1, 16'h0300, 2, 2, 1, 1, "R12");
    pop_r(8'h11, "R12"); pop_r(8'h22, "R12"); pop_r(8'h00, "R12");

    // R13: read queue cleared by go
    rsrc = '{8'hC1, 8'hC2};
    run_burst(0, 0, 16'h0400, 2, 2, 1, 0, "R13");
    pop_r(8'hC1, "R13");
    rsrc = '{8'hD1};
    run_burst(0, 0, 16'h0400, 1, 1, 1, 0, "R13");
    pop_r(8'hD1, "R13"); pop_r(8'h00, "R13");

    // R14: count of zero
    run_burst(0, 0, 16'h0500, 0, 0, 1, 0, "R14");

    repeat (5) @(negedge clk);
    report();
    $finish;
  end
endmodule